// File: doc/BRIEF.md
# Dual-Bank Oscillation Count Acquisition Controller

This block runs a single measurement of a transient-oscillator fingerprint array. The cells sit in two banks of 128. A challenge word names one cell in each bank. On an accepted start, the block raises the enable line of only those two cells for a programmable number of system clock cycles. While the window is open, it counts rising edges on the output of each chosen cell, with a separate counter for each bank.

Each selected cell output is picked through a per-bank multiplexer. It then crosses into the clock domain through a short synchronizer and a rising-edge detector. Only after that can it advance its counter. When the window closes, a one-cycle done pulse marks the two counts as valid. The counts then stay at the outputs until the next accepted start. Post-processing of the counts, such as subtracting them or encoding the difference, is left to logic downstream.

Top module: `osc_acq_ctrl`

## Requirements
- R1: The low 7 challenge bits (bits [6:0]) choose the bank A cell and the high 7 bits (bits [13:7]) choose the bank B cell. While the window is open, `init_a` and `init_b` are one-hot at the chosen index. At all other times they are all zero.
- R2: After a start is accepted, the enable of the chosen cells is high for exactly `win_len` consecutive cycles, starting the cycle after the start edge. A `win_len` of 0 gives a window of one cycle.
- R3: Each counter counts only rising edges of the chosen cell in its own bank. Activity on any other cell input has no effect on the counts.
- R4: A cell edge passes two synchronizer flops and an edge detector before it counts. A rise applied in window cycle j (numbered from 1) is counted only if j is at most `win_len`-2. Later rises, including those still in the synchronizer when the window closes, are not counted.
- R5: A counter that reaches its all-ones value holds there instead of wrapping.
- R6: Both counters clear on an accepted start. After the window they hold their values, whatever the cell inputs do, until the next accepted start.
- R7: `done` is high for exactly one cycle: the first cycle after the window. `busy` is high from the cycle after the start edge through the `done` cycle.
- R8: A start that arrives while `busy` is high is ignored. The selection and the window length of the measurement in progress are unchanged.
- R9: During and right after reset, `busy`, `done`, both enable vectors and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a measurement; sampled only when idle |
| challenge | input | 14 | Cell selection: [6:0] bank A, [13:7] bank B |
| win_len | input | 16 | Window length in clock cycles (0 acts as 1) |
| cell_a | input | 128 | Outputs of the bank A cells |
| cell_b | input | 128 | Outputs of the bank B cells |
| init_a | output | 128 | Enables for the bank A cells |
| init_b | output | 128 | Enables for the bank B cells |
| busy | output | 1 | Measurement in progress, including the done cycle |
| done | output | 1 | One-cycle pulse marking valid counts |
| count_a | output | 16 | Saturating edge count of the chosen bank A cell |
| count_b | output | 16 | Saturating edge count of the chosen bank B cell |

## Verification
A start driven on the falling edge before clock edge E0 shows as `busy` and enabled cells after E0. The enables stay up across the next `win_len` edges, and `done` appears after edge E(`win_len`). The bench therefore numbers the falling edges j = 1, 2, … after the start and samples at each one. It expects the enables for j = 1..`win_len` and `done` at j = `win_len`+1. Because of the synchronizer, a rise driven at falling edge j is counted at edge E(j+2). The bench's expected count therefore accepts only rises with j ≤ `win_len`-2. The count outputs are read once the block is idle again.

// File: rtl/osc_acq_pkg.sv
package osc_acq_pkg;
   typedef enum logic [1:0] {
      ACQ_IDLE = 2'd0,
      ACQ_RUN  = 2'd1,
      ACQ_DONE = 2'd2
   } acq_state_t;

   localparam int NUM_BANKS = 2;
endpackage

// File: rtl/osc_acq_window.sv
module osc_acq_window
   import osc_acq_pkg::*;
#(
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIN_W-1:0] win_len,
   output logic             accept,
   output logic             run,
   output logic             done,
   output logic             busy
);
   acq_state_t       state_q;
   logic [WIN_W-1:0] left_q;
   logic [WIN_W-1:0] load_len;

   assign accept   = start && (state_q == ACQ_IDLE);
   assign load_len = (win_len == '0) ? {{(WIN_W-1){1'b0}}, 1'b1} : win_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ACQ_IDLE;
         left_q  <= '0;
      end else begin
         unique case (state_q)
            ACQ_IDLE: begin
               if (start) begin
                  state_q <= ACQ_RUN;
                  left_q  <= load_len;
               end
            end
            ACQ_RUN: begin
               if (left_q == {{(WIN_W-1){1'b0}}, 1'b1}) begin
                  state_q <= ACQ_DONE;
               end
               left_q <= left_q - 1'b1;
            end
            ACQ_DONE: state_q <= ACQ_IDLE;
            default:  state_q <= ACQ_IDLE;
         endcase
      end
   end

   assign run  = (state_q == ACQ_RUN);
   assign done = (state_q == ACQ_DONE);
   assign busy = (state_q != ACQ_IDLE);

   // R7: done lasts one cycle only
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: done always follows an open window
   assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(run));
   // R8: a start while busy never restarts the window
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && left_q != {{(WIN_W-1){1'b0}}, 1'b1}) |=> run);
endmodule

// File: rtl/osc_bank_sel.sv
module osc_bank_sel #(
   parameter int NCELLS = 128,
   localparam int SELW  = $clog2(NCELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [SELW-1:0]   sel,
   input  logic [NCELLS-1:0] cell_in,
   output logic [NCELLS-1:0] init_vec,
   output logic              tap
);
   for (genvar i = 0; i < NCELLS; i++) begin : g_en
      assign init_vec[i] = run && (sel == SELW'(i));
   end

   assign tap = cell_in[sel];

   // R1: never more than one enabled cell per bank
   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(init_vec));
endmodule

// File: rtl/osc_edge_count.sv
module osc_edge_count #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             tap,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       cnt_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else if (clr) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q[0] <= tap;
         for (int k = 1; k < SYNC_STAGES; k++) begin
            sync_q[k] <= sync_q[k-1];
         end
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] && !prev_q;

   if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (en && rise) begin
         cnt_q <= cnt_inc;
      end
   end

   assign cnt = cnt_q;

   // R6: outside the window and without a clear, the count holds
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt_q));
   // R4: count moves by at most one per cycle
   assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
   if (SATURATE) begin : g_sat_chk
      // R5: a full counter never wraps
      assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
   end
endmodule

// File: rtl/osc_acq_ctrl.sv
module osc_acq_ctrl
   import osc_acq_pkg::*;
#(
   parameter int NCELLS      = 128,
   parameter int CNT_W       = 16,
   parameter int WIN_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1,
   localparam int SELW       = $clog2(NCELLS),
   localparam int CHAL_W     = NUM_BANKS * SELW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CHAL_W-1:0] challenge,
   input  logic [WIN_W-1:0]  win_len,
   input  logic [NCELLS-1:0] cell_a,
   input  logic [NCELLS-1:0] cell_b,
   output logic [NCELLS-1:0] init_a,
   output logic [NCELLS-1:0] init_b,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  count_a,
   output logic [CNT_W-1:0]  count_b
);
   if (NCELLS < 2 || (1 << SELW) != NCELLS) begin : g_bad_cells
      $error("NCELLS must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (CNT_W < 2 || WIN_W < 1) begin : g_bad_width
      $error("CNT_W must be at least 2 and WIN_W at least 1");
   end

   logic accept;
   logic run;

   logic [NUM_BANKS-1:0][SELW-1:0]   sel_q;
   logic [NUM_BANKS-1:0][NCELLS-1:0] cells;
   logic [NUM_BANKS-1:0][NCELLS-1:0] inits;
   logic [NUM_BANKS-1:0][CNT_W-1:0]  counts;
   logic [NUM_BANKS-1:0]             taps;

   osc_acq_window #(.WIN_W(WIN_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .win_len (win_len),
      .accept  (accept),
      .run     (run),
      .done    (done),
      .busy    (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (accept) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            sel_q[b] <= challenge[b*SELW +: SELW];
         end
      end
   end

   assign cells[0] = cell_a;
   assign cells[1] = cell_b;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      osc_bank_sel #(.NCELLS(NCELLS)) u_sel (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run),
         .sel      (sel_q[b]),
         .cell_in  (cells[b]),
         .init_vec (inits[b]),
         .tap      (taps[b])
      );

      osc_edge_count #(
         .CNT_W       (CNT_W),
         .SYNC_STAGES (SYNC_STAGES),
         .SATURATE    (SATURATE)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (accept),
         .en    (run),
         .tap   (taps[b]),
         .cnt   (counts[b])
      );
   end

   assign init_a  = inits[0];
   assign init_b  = inits[1];
   assign count_a = counts[0];
   assign count_b = counts[1];

   // R8: selection is frozen for the whole measurement
   assert_sel_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(sel_q));
   // R1: cells are enabled only while a measurement is under way
   assert_init_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|{init_a, init_b}) |-> busy);
   // R7: done is seen only while busy
   assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

// File: tb/osc_acq_ctrl_test.sv
module osc_acq_ctrl_test;
   localparam int N  = 128;
   localparam int CW = 8;
   localparam int WW = 10;
   localparam int CMAX = (1 << CW) - 1;

   typedef struct packed {
      int ia;
      int ib;
      int len;
      int pa;
      int pb;
      int intr;
   } vec_t;

   // idx A, idx B, window, pulses A, pulses B, start-while-busy
   localparam vec_t VECS [4] = '{
      '{5,   100, 30,  3,  7,   0},
      '{127, 0,   60,  20, 0,   0},
      '{0,   127, 500, 50, 124, 0},
      '{64,  63,  12,  2,  3,   1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [13:0]   challenge = '0;
   logic [WW-1:0] win_len = '0;
   logic [N-1:0]  cell_a = '0;
   logic [N-1:0]  cell_b = '0;
   logic [N-1:0]  init_a;
   logic [N-1:0]  init_b;
   logic          busy;
   logic          done;
   logic [CW-1:0] count_a;
   logic [CW-1:0] count_b;

   int total = 0;
   int bad   = 0;

   osc_acq_ctrl #(.NCELLS(N), .CNT_W(CW), .WIN_W(WW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
      .win_len(win_len), .cell_a(cell_a), .cell_b(cell_b),
      .init_a(init_a), .init_b(init_b), .busy(busy), .done(done),
      .count_a(count_a), .count_b(count_b)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit lvl(int j, int f, int per, int p);
      if (j < f) return 1'b0;
      return (((j - f) % per) < (per / 2)) && (((j - f) / per) < p);
   endfunction

   function automatic int exp_cnt(int f, int per, int p, int len);
      int le = (len == 0) ? 1 : len;
      int n = 0;
      for (int k = 0; k < p; k++) begin
         if (f + per * k <= le - 2) n++;
      end
      return (n > CMAX) ? CMAX : n;
   endfunction

   task automatic run_acq(input int ia, input int ib, input int len, input int f,
                          input int per, input int pa, input int pb, input bit intr,
                          input string tag);
      int le = (len == 0) ? 1 : len;
      int init_hi = 0;
      int done_at = -1;
      int done_n = 0;
      int pat_bad = 0;
      int busy_bad = 0;
      logic [13:0] chal;
      chal = {7'(ib), 7'(ia)};
      @(negedge clk);
      start = 1'b1; challenge = chal; win_len = WW'(len);
      for (int j = 1; j <= le + 6; j++) begin
         @(negedge clk);
         start = intr && (j == 3);
         if (intr && j == 3) begin
            challenge = ~chal; win_len = WW'(5);
         end
         cell_a = j[0] ? '1 : '0;
         cell_b = j[0] ? '0 : '1;
         cell_a[ia] = lvl(j, f, per, pa);
         cell_b[ib] = lvl(j, f, per, pb);
         if (j <= le) begin
            if (init_a == (N'(1) << ia) && init_b == (N'(1) << ib)) init_hi++;
            else pat_bad++;
         end else if (init_a != '0 || init_b != '0) pat_bad++;
         if (done) begin
            done_n++;
            if (done_at < 0) done_at = j;
         end
         if (busy != (j <= le + 1)) busy_bad++;
      end
      cell_a = '0; cell_b = '0;
      check(init_hi == le, {tag, " R2 window length"}, init_hi, le);
      check(pat_bad == 0, {tag, " R1 enable pattern"}, pat_bad, 0);
      check(done_at == le + 1 && done_n == 1, {tag, " R7 done timing"}, done_at, le + 1);
      check(busy_bad == 0, {tag, " R7 busy span"}, busy_bad, 0);
      check(int'(count_a) == exp_cnt(f, per, pa, len), {tag, " R3 count A"},
            count_a, exp_cnt(f, per, pa, len));
      check(int'(count_b) == exp_cnt(f, per, pb, len), {tag, " R3 count B"},
            count_b, exp_cnt(f, per, pb, len));
   endtask

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(100000 * 10);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0, "R9 flags in reset", {busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(init_a == '0 && init_b == '0, "R9 enables after reset", 1, 0);
      check(count_a == 0 && count_b == 0, "R9 counts after reset", count_a, 0);

      // table of vectors; R8 covered by the entry that pulses start mid-run
      foreach (VECS[v]) begin
         run_acq(VECS[v].ia, VECS[v].ib, VECS[v].len, 1, 4, VECS[v].pa, VECS[v].pb,
                 VECS[v].intr != 0, $sformatf("vec%0d", v));
      end

      // R4: last countable rise is in window cycle len-2
      run_acq(9, 90, 10, 8, 4, 1, 1, 1'b0, "R4 rise at len-2");
      // R6: counts hold after the window while the inputs keep toggling
      for (int j = 0; j < 6; j++) begin
         @(negedge clk);
         cell_a = j[0] ? '1 : '0;
         cell_b = j[0] ? '1 : '0;
      end
      check(count_a == 1 && count_b == 1, "R6 hold after done", count_a, 1);
      cell_a = '0; cell_b = '0;
      // R4 and R6: rise at len-1 is lost; the start cleared the old count
      run_acq(9, 90, 10, 9, 4, 1, 1, 1'b0, "R4 rise at len-1");
      // R2: zero window acts as one cycle
      run_acq(33, 44, 0, 1, 4, 1, 1, 1'b0, "R2 zero window");
      // R5: saturation with a rise every two cycles
      run_acq(1, 2, 900, 1, 2, 440, 440, 1'b0, "R5 saturate");
      check(count_a == CW'(CMAX), "R5 holds at max", count_a, CMAX);

      finish_up();
   end
endmodule